// File: doc/BRIEF.md
# Paged DMA Transfer Address Generator

This block produces the physical memory address for each transfer of one DMA channel during a block transfer. Software or a sequencer programs it with a load pulse. The pulse carries a page value, a 16-bit starting address, a 16-bit count that is one less than the number of transfers, and a size bit that selects byte or word granularity. After the load, every advance pulse issues one transfer. One cycle later the block presents the 24-bit physical address of that transfer, raises a one-cycle valid strobe, and moves its address and count on by one step.

In byte mode the page forms the top eight address bits above the 16-bit address counter. In word mode the counter is moved up one bit position, bit 0 of the physical address is zero, and the lowest page bit is dropped. This gives 128K-byte windows. In both modes the counter wraps inside its window and never carries into the page. The transfer that consumes the last count raises terminal count, and the channel then goes idle until the next load.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, busy_o, xfer_valid_o and tc_o are 0 and phys_addr_o is 0.
- R2: A load_i pulse captures page_i, addr_i, count_i and word_mode_i and sets busy_o on the next cycle. The load emits no transfer.
- R3: In byte mode (word_mode_i=0 at load), phys_addr_o[23:16] equals the loaded page and phys_addr_o[15:0] equals the address counter.
- R4: In word mode (word_mode_i=1 at load), phys_addr_o[0] is 0, phys_addr_o[16:1] equals the address counter, and phys_addr_o[23:17] equals page bits 7:1. Page bit 0 has no effect.
- R5: Each issued transfer adds one to the address counter. The counter wraps from 0xFFFF to 0x0000, and the page part of phys_addr_o stays the same for the whole block.
- R6: A loaded count of N issues exactly N+1 transfers. A count of 0 issues exactly one.
- R7: tc_o is 1 together with xfer_valid_o on the final transfer only. busy_o is 0 from that same cycle.
- R8: An advance_i pulse while busy_o is 0 produces no strobe and leaves phys_addr_o unchanged.
- R9: A load while busy restarts the block from the new values. When load_i and advance_i are both high, the load wins and no transfer is issued.
- R10: The transfer size is fixed at load. Changing word_mode_i during a block has no effect.
- R11: The outputs respond to advance_i one cycle later: xfer_valid_o, tc_o and phys_addr_o update on the clock edge that samples the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load pulse: capture programming values and start a block |
| page_i | input | 8 | Page value |
| addr_i | input | 16 | Starting address counter value |
| count_i | input | 16 | Transfers minus one |
| word_mode_i | input | 1 | 1 = 16-bit word transfers, 0 = byte transfers |
| advance_i | input | 1 | Issue one transfer |
| busy_o | output | 1 | Channel holds a block that is not finished |
| xfer_valid_o | output | 1 | One-cycle strobe: phys_addr_o belongs to an issued transfer |
| phys_addr_o | output | 24 | Physical address of the last issued transfer |
| tc_o | output | 1 | Terminal count, high with the final transfer |

## Verification
Several rules are checked by assertions on every cycle:
- terminal count always comes with a valid strobe and leaves the channel idle;
- a load never issues a transfer;
- the address holds steady between strobes;
- back-to-back strobes keep the page bits constant and step the byte-mode counter by one.

Other behaviour can only be shown by the bench's scenarios comparing against a behavioural model on every clock. This covers the exact number of transfers for a given count, wrapping at 0xFFFF, the loss of page bit 0 in word mode, and the restart on reload.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  typedef enum logic {
    XSZ_BYTE = 1'b0,
    XSZ_WORD = 1'b1
  } xfer_size_e;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;

endpackage

// File: rtl/dma_ag_ctrl.sv
module dma_ag_ctrl
  import dma_ag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic advance_i,
  input  logic cnt_zero_i,
  output logic busy_o,
  output logic issue_o,
  output logic last_o
);

  ch_state_e state_q, state_d;

  // A load takes priority over an advance in the same cycle.
  assign issue_o = advance_i && !load_i && (state_q == CH_RUN);
  assign last_o  = issue_o && cnt_zero_i;
  assign busy_o  = (state_q == CH_RUN);

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = CH_RUN;
    end else if (last_o) begin
      state_d = CH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/dma_ag_regs.sv
module dma_ag_regs
  import dma_ag_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              issue_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CNT_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              word_mode_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [CNT_W-1:0]  addr_o,
  output xfer_size_e        size_o,
  output logic              cnt_zero_o
);

  logic [PAGE_W-1:0] page_q, page_d;
  logic [CNT_W-1:0]  addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  xfer_size_e        size_q, size_d;
  logic              regs_en;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign regs_en = load_i || issue_i;

  always_comb begin
    page_d = page_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    size_d = size_q;
    if (load_i) begin
      page_d = page_i;
      addr_d = addr_i;
      cnt_d  = count_i;
      size_d = word_mode_i ? XSZ_WORD : XSZ_BYTE;
    end else if (issue_i) begin
      // Wraps inside the window; no carry into the page.
      addr_d = addr_q + ONE;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      size_q <= XSZ_BYTE;
    end else if (regs_en) begin
      page_q <= page_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      size_q <= size_d;
    end
  end

  assign page_o     = page_q;
  assign addr_o     = addr_q;
  assign size_o     = size_q;
  assign cnt_zero_o = (cnt_q == '0);

endmodule

// File: rtl/dma_ag_map.sv
module dma_ag_map
  import dma_ag_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  localparam int PHYS_W = PAGE_W + CNT_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CNT_W-1:0]  addr_i,
  input  xfer_size_e        size_i,
  output logic [PHYS_W-1:0] phys_o
);

  logic [PHYS_W-1:0] byte_addr;
  logic [PHYS_W-1:0] word_addr;

  // Byte granularity: page directly above the counter.
  assign byte_addr = {page_i, addr_i};

  // Word granularity: counter moved up one bit, lowest page bit dropped.
  generate
    if (PAGE_W > 1) begin : g_wide_page
      assign word_addr = {page_i[PAGE_W-1:1], addr_i, 1'b0};
    end else begin : g_narrow_page
      assign word_addr = {addr_i, 1'b0};
    end
  endgenerate

  assign phys_o = (size_i == XSZ_WORD) ? word_addr : byte_addr;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  localparam int PHYS_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CNT_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              word_mode_i,
  input  logic              advance_i,
  output logic              busy_o,
  output logic              xfer_valid_o,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic              tc_o
);

  logic              issue;
  logic              last;
  logic              cnt_zero;
  logic [PAGE_W-1:0] page_w;
  logic [CNT_W-1:0]  addr_w;
  xfer_size_e        size_w;
  logic [PHYS_W-1:0] phys_w;

  logic              valid_q, valid_d;
  logic              tc_q,    tc_d;
  logic [PHYS_W-1:0] phys_q,  phys_d;

  dma_ag_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .advance_i  (advance_i),
    .cnt_zero_i (cnt_zero),
    .busy_o     (busy_o),
    .issue_o    (issue),
    .last_o     (last)
  );

  dma_ag_regs #(
    .PAGE_W (PAGE_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .issue_i     (issue),
    .page_i      (page_i),
    .addr_i      (addr_i),
    .count_i     (count_i),
    .word_mode_i (word_mode_i),
    .page_o      (page_w),
    .addr_o      (addr_w),
    .size_o      (size_w),
    .cnt_zero_o  (cnt_zero)
  );

  dma_ag_map #(
    .PAGE_W (PAGE_W),
    .CNT_W  (CNT_W)
  ) u_map (
    .page_i (page_w),
    .addr_i (addr_w),
    .size_i (size_w),
    .phys_o (phys_w)
  );

  // Output stage: strobes follow every edge, address only on an issue.
  always_comb begin
    valid_d = issue;
    tc_d    = last;
    phys_d  = issue ? phys_w : phys_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      tc_q    <= tc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_q <= '0;
    end else if (issue) begin
      phys_q <= phys_d;
    end
  end

  assign xfer_valid_o = valid_q;
  assign tc_o         = tc_q;
  assign phys_addr_o  = phys_q;

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  localparam int PHYS_W = PAGE_W + CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              busy_o,
  input logic              xfer_valid_o,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic              tc_o,
  input logic              word_sel
);

  // R7: terminal count only rides on a strobe
  p_tc_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> xfer_valid_o);

  // R7: the channel is idle once the final transfer is out
  p_tc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> !busy_o);

  // R2: a load starts the channel and issues nothing
  p_load_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (busy_o && !xfer_valid_o));

  // R8: no strobe can follow an idle, non-loading cycle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i) |=> !xfer_valid_o);

  // R11: the address only changes together with a strobe
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid_o |-> $stable(phys_addr_o));

  // R5: page bits constant between back-to-back strobes
  p_page_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && $past(xfer_valid_o)) |->
      (phys_addr_o[PHYS_W-1:CNT_W+1] == $past(phys_addr_o[PHYS_W-1:CNT_W+1])));

  // R5: byte-mode counter steps by one between back-to-back strobes
  p_byte_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && $past(xfer_valid_o) && !word_sel) |->
      (phys_addr_o[CNT_W-1:0] == $past(phys_addr_o[CNT_W-1:0]) + CNT_W'(1)));

  // R4: word transfers are always even
  p_word_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && word_sel && $past(xfer_valid_o)) |-> !phys_addr_o[0]);

endmodule

bind dma_addr_gen dma_addr_gen_chk #(
  .PAGE_W (PAGE_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .busy_o       (busy_o),
  .xfer_valid_o (xfer_valid_o),
  .phys_addr_o  (phys_addr_o),
  .tc_o         (tc_o),
  .word_sel     (size_w == dma_ag_pkg::XSZ_WORD)
);

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [7:0]  page_i;
  logic [15:0] addr_i;
  logic [15:0] count_i;
  logic        word_mode_i;
  logic        advance_i;
  logic        busy_o;
  logic        xfer_valid_o;
  logic [23:0] phys_addr_o;
  logic        tc_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  bit     m_active;
  int     m_page, m_addr, m_cnt;
  bit     m_word;
  bit     e_busy, e_valid, e_tc;
  int     e_phys;
  int     n_valid, n_tc;

  dma_addr_gen dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .page_i       (page_i),
    .addr_i       (addr_i),
    .count_i      (count_i),
    .word_mode_i  (word_mode_i),
    .advance_i    (advance_i),
    .busy_o       (busy_o),
    .xfer_valid_o (xfer_valid_o),
    .phys_addr_o  (phys_addr_o),
    .tc_o         (tc_o)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic int map_addr(bit w, int pg, int ad);
    if (w) return ((pg & 'hFE) << 16) | (ad << 1);
    return (pg << 16) | ad;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_page = 0; m_addr = 0; m_cnt = 0; m_word = 0;
      e_valid = 0; e_tc = 0; e_phys = 0; e_busy = 0;
    end else begin
      e_valid = 0; e_tc = 0;
      if (load_i) begin
        m_active = 1; m_page = page_i; m_addr = addr_i;
        m_cnt = count_i; m_word = word_mode_i;
      end else if (advance_i && m_active) begin
        e_valid = 1;
        e_phys  = map_addr(m_word, m_page, m_addr);
        e_tc    = (m_cnt == 0);
        m_addr  = (m_addr + 1) & 'hFFFF;
        if (m_cnt == 0) m_active = 0;
        else m_cnt = m_cnt - 1;
      end
      e_busy = m_active;
      if (e_valid) n_valid++;
      if (e_tc) n_tc++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "busy", busy_o, e_busy);
      check(cur_req, "valid", xfer_valid_o, e_valid);
      check(cur_req, "tc", tc_o, e_tc);
      check(cur_req, "phys", phys_addr_o, e_phys);
    end
  end

  task automatic idle_cycle();
    @(negedge clk); #1;
    load_i = 0; advance_i = 0;
  endtask

  task automatic do_load(bit w, int pg, int ad, int cn);
    @(negedge clk); #1;
    load_i = 1; advance_i = 0; word_mode_i = w;
    page_i = pg[7:0]; addr_i = ad[15:0]; count_i = cn[15:0];
    @(negedge clk); #1;
    load_i = 0;
  endtask

  task automatic do_adv();
    @(negedge clk); #1;
    advance_i = 1;
    @(negedge clk); #1;
    advance_i = 0;
  endtask

  task automatic run_block(int nadv);
    n_valid = 0; n_tc = 0;
    for (int i = 0; i < nadv; i++) do_adv();
    idle_cycle();
  endtask

  initial begin
    #100000;
    $display("FAIL watchdog: actual=hung expected=finished");
    errors++; checks++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; load_i = 0; advance_i = 0; word_mode_i = 0;
    page_i = 0; addr_i = 0; count_i = 0;
    #12;
    // R1: reset values
    check("R1", "reset busy", busy_o, 0);
    check("R1", "reset valid", xfer_valid_o, 0);
    check("R1", "reset tc", tc_o, 0);
    check("R1", "reset phys", phys_addr_o, 0);
    @(negedge clk); #1; rst_n = 1;
    idle_cycle();

    // R8: advances while idle
    cur_req = "R8";
    run_block(3);
    check("R8", "idle strobes", n_valid, 0);
    check("R8", "idle phys", phys_addr_o, 0);

    // R3 R5 R6 R7: byte block, wrap at 0xFFFF, count 3 -> 4 transfers
    cur_req = "R3";
    do_load(0, 'h12, 'hFFFE, 3);
    check("R2", "busy after load", busy_o, 1);
    cur_req = "R5";
    run_block(6);
    check("R6", "byte transfers", n_valid, 4);
    check("R7", "byte tc pulses", n_tc, 1);
    check("R5", "wrapped addr", phys_addr_o, 'h120001);
    check("R7", "idle after tc", busy_o, 0);

    // R4: word block, odd page, wrap
    cur_req = "R4";
    do_load(1, 'h35, 'hFFFF, 2);
    run_block(3);
    check("R4", "word transfers", n_valid, 3);
    check("R4", "word last addr", phys_addr_o, 'h340002);

    // R6: count 0 gives one transfer
    cur_req = "R6";
    do_load(0, 'hFF, 'h1234, 0);
    run_block(3);
    check("R6", "single transfer", n_valid, 1);
    check("R7", "single tc", n_tc, 1);

    // R11: back-to-back advances, one-cycle latency
    cur_req = "R11";
    do_load(0, 'h01, 'h0010, 7);
    n_valid = 0; n_tc = 0;
    @(negedge clk); #1; advance_i = 1;
    repeat (4) begin @(negedge clk); #1; end
    advance_i = 0;
    check("R11", "burst strobes", n_valid, 4);

    // R9: reload mid-block, and load+advance together
    cur_req = "R9";
    @(negedge clk); #1;
    load_i = 1; advance_i = 1; page_i = 'h80; addr_i = 'h0100; count_i = 1;
    word_mode_i = 0;
    @(negedge clk); #1;
    load_i = 0; advance_i = 0;
    check("R9", "no strobe on load", xfer_valid_o, 0);
    run_block(4);
    check("R9", "restart transfers", n_valid, 2);
    check("R9", "restart last addr", phys_addr_o, 'h800101);

    // R10: mode change mid-block ignored
    cur_req = "R10";
    do_load(1, 'h07, 'h0040, 2);
    do_adv();
    word_mode_i = 0;
    run_block(3);
    check("R10", "word kept", phys_addr_o, 'h060084);

    idle_cycle();
    idle_cycle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule